// File: doc/BRIEF.md
# Page-Splitting Serial EEPROM Write Master

This block is the host side of an SPI link to a serial EEPROM that programs in 128-byte pages. A client hands it one write request: a 16-bit start address and a byte count. It then streams the payload over a valid/ready byte port. The block cuts the request into chunks so that no chunk crosses a page boundary.

For each chunk the block runs three kinds of frame. First comes a one-byte write-enable frame. Next comes a program frame with the opcode, the address and the chunk's bytes. After that it sends status-read frames until the device reports that it is no longer busy. The serial clock comes from a divider of the system clock. Chip select stays high for a set number of serial clock periods between any two frames. A single-cycle completion pulse closes the request.

The block takes a request only while it is idle. A request of zero length completes at once and sends no frame.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, done is 0, wr_ready is 0 and req_ready is 1.
- R2: The serial clock uses mode 0. SCK idles low, each bit of spi_mosi is set up while SCK is low and held stable while SCK is high, and bytes go out most significant bit first. Each SCK phase lasts HALF_DIV system clock cycles.
- R3: Each chunk starts with a frame that holds exactly the single byte 0x06 (write enable). CS is raised after it.
- R4: A program frame carries the byte 0x02, then the address high byte, then the address low byte, then the chunk's data in stream order. CS rises right after the eighth bit of the last data byte, with no further SCK pulse.
- R5: The chunk length is the smaller of two values: the bytes still owed, and 128 minus (address mod 128). A chunk never crosses a multiple of 128, and the address wraps from 0xFFFF to 0x0000.
- R6: After each program frame the block sends status frames of two bytes each: 0x05, then the dummy 0x00. The busy flag is bit 0 of the byte returned during the dummy byte. The block repeats the status frame while that bit is 1. It starts the next chunk, or finishes, only after the bit reads 0. The other status bits have no effect.
- R7: Between any two frames, CS stays high for at least CS_GAP_SCK × 2 × HALF_DIV system clock cycles. SCK stays low while CS is high.
- R8: done is a one-cycle pulse, raised only while idle, after the final status frame of the final chunk and the gap that follows it. A request presented while req_ready is 0 is ignored and does not change the frames that are sent.
- R9: A request with length 0 pulses done without any CS frame.
- R10: Data bytes are taken one per wr_valid && wr_ready. While wr_valid is low inside a program frame, the frame pauses with CS low and SCK low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | 16 | First EEPROM byte address |
| req_len | input | LEN_W | Number of payload bytes |
| wr_valid | input | 1 | Payload byte present |
| wr_ready | output | 1 | Payload byte taken this cycle |
| wr_data | input | 8 | Payload byte |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The hardest situation to reach from the ports is a busy device that needs several status reads in a row. On top of that come a request that spans three pages, a request that wraps past the top of the address space, and a payload stream that stalls in the middle of a frame. The bench decodes every frame from the serial pins. A device model answers the dummy byte with a busy status for a chosen number of polls after each program frame, and sets the unused status bits high. Each scenario then compares the whole decoded frame list against a list rebuilt from the page arithmetic. One scenario stalls the payload for longer than a byte time to catch the paused frame. Another offers a second request while the first is still running.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  localparam logic [7:0] OP_ARM   = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_POLL  = 8'h05;
  localparam logic [7:0] BYTE_PAD = 8'h00;
  localparam logic [7:0] BUSY_MASK = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_POLL_CMD,
    ST_POLL_RD,
    ST_GAP
  } eepw_state_e;

  // Bytes that fit in the current page, capped by what is still owed.
  function automatic int unsigned page_chunk(input int unsigned addr,
                                             input int unsigned owed,
                                             input int unsigned page);
    int unsigned room;
    room = page - (addr % page);
    return (owed < room) ? owed : room;
  endfunction

  // Minimum chip-select high time in system clock cycles.
  function automatic int unsigned gap_cycles(input int unsigned gap_sck,
                                             input int unsigned half);
    return gap_sck * 2 * half;
  endfunction

endpackage

// File: rtl/eepw_byte_shift.sv
module eepw_byte_shift #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic [2:0]    bit_idx;
  logic [7:0]    sh;
  logic          half_end;

  assign half_end = (cnt == CW'(HALF_DIV - 1));
  assign mosi     = busy & sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      sck     <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      sh      <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        sh      <= tx_byte;
        cnt     <= '0;
        bit_idx <= '0;
        sck     <= 1'b0;
      end else if (busy) begin
        if (half_end) begin
          cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              sh      <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: clock rests low outside a byte
  p_sck_rest_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R2: data held while the clock is high
  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/eepw_gap_timer.sv
module eepw_gap_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign expired = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CW'(CYCLES - 1);
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  // R7: one expiry per started gap
  p_expire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !start) |=> !expired);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eepw_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned CS_GAP_SCK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int unsigned PB      = $clog2(PAGE_BYTES);
  localparam int unsigned CW      = PB + 1;
  localparam int unsigned GAP_CYC = gap_cycles(CS_GAP_SCK, HALF_DIV);

  eepw_state_e      state, gap_next;
  logic [15:0]      cur_addr;
  logic [LEN_W-1:0] owed;
  logic [CW-1:0]    chunk_left;
  logic             launched, first_data, done_q;

  logic       byte_state, sh_start, sh_busy, sh_done, frame_end, gap_exp;
  logic       data_fire, poll_busy;
  logic [7:0] tx_byte, rx_byte;

  assign byte_state = (state != ST_IDLE) && (state != ST_GAP);
  assign wr_ready   = (state == ST_DATA) && !launched;
  assign sh_start   = byte_state && !launched && ((state != ST_DATA) || wr_valid);
  assign data_fire  = wr_valid && wr_ready;
  assign poll_busy  = |(rx_byte & BUSY_MASK);
  assign frame_end  = sh_done && ((state == ST_ARM) || (state == ST_POLL_RD) ||
                                  ((state == ST_DATA) && (chunk_left == '0)));
  assign req_ready  = (state == ST_IDLE);
  assign spi_cs_n   = (state == ST_IDLE) || (state == ST_GAP);
  assign done       = done_q;

  always_comb begin
    case (state)
      ST_ARM:      tx_byte = OP_ARM;
      ST_CMD:      tx_byte = OP_PROG;
      ST_AHI:      tx_byte = cur_addr[15:8];
      ST_ALO:      tx_byte = cur_addr[7:0];
      ST_DATA:     tx_byte = wr_data;
      ST_POLL_CMD: tx_byte = OP_POLL;
      default:     tx_byte = BYTE_PAD;
    endcase
  end

  eepw_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_byte),
    .miso(spi_miso), .busy(sh_busy), .done(sh_done), .rx_byte(rx_byte),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  eepw_gap_timer #(.CYCLES(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(frame_end), .expired(gap_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      gap_next   <= ST_IDLE;
      cur_addr   <= '0;
      owed       <= '0;
      chunk_left <= '0;
      launched   <= 1'b0;
      first_data <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sh_start)     launched <= 1'b1;
      else if (sh_done) launched <= 1'b0;
      if (data_fire) begin
        cur_addr   <= cur_addr + 16'd1;
        owed       <= owed - 1'b1;
        chunk_left <= chunk_left - 1'b1;
        first_data <= 1'b0;
      end
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          owed     <= req_len;
          if (req_len == '0) done_q <= 1'b1;
          else begin
            chunk_left <= CW'(page_chunk(32'(req_addr), 32'(req_len), PAGE_BYTES));
            state      <= ST_ARM;
          end
        end
        ST_ARM: if (sh_done) begin
          state    <= ST_GAP;
          gap_next <= ST_CMD;
        end
        ST_CMD: if (sh_done) state <= ST_AHI;
        ST_AHI: if (sh_done) state <= ST_ALO;
        ST_ALO: if (sh_done) begin
          state      <= ST_DATA;
          first_data <= 1'b1;
        end
        ST_DATA: if (sh_done && chunk_left == '0) begin
          state    <= ST_GAP;
          gap_next <= ST_POLL_CMD;
        end
        ST_POLL_CMD: if (sh_done) state <= ST_POLL_RD;
        ST_POLL_RD: if (sh_done) begin
          state <= ST_GAP;
          if (poll_busy)         gap_next <= ST_POLL_CMD;
          else if (owed == '0)   gap_next <= ST_IDLE;
          else begin
            gap_next   <= ST_ARM;
            chunk_left <= CW'(page_chunk(32'(cur_addr), 32'(owed), PAGE_BYTES));
          end
        end
        ST_GAP: if (gap_exp) begin
          state <= gap_next;
          if (gap_next == ST_IDLE) done_q <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker state: consecutive cycles with chip select high, saturating.
  int unsigned hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= GAP_CYC;
    else if (!spi_cs_n)      hi_cnt <= 0;
    else if (hi_cnt < GAP_CYC) hi_cnt <= hi_cnt + 1;
  end

  // R5: a data byte after the first in a frame never lands on a page start
  p_no_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_fire && !first_data) |-> (cur_addr[PB-1:0] != '0));

  // R7: chip select high long enough before each frame
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= GAP_CYC));

  // R7: clock quiet while deselected
  p_sck_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R8: completion only while idle
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R3: arm frame closed right after its single byte
  p_arm_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && sh_done) |=> spi_cs_n);

  // R10: shifter never runs while data frame waits for a byte
  p_wait_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !sh_busy);

endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int HALF = 2;
  localparam int GAPS = 2;
  localparam int GAP_CYC = GAPS * 2 * HALF;
  localparam int PAGE = 128;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, wr_valid, wr_ready, done;
  logic [15:0] req_addr, req_len;
  logic [7:0]  wr_data;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  eeprom_page_writer #(.PAGE_BYTES(PAGE), .LEN_W(16), .HALF_DIV(HALF),
                       .CS_GAP_SCK(GAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .done(done),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- device model / frame monitor ----------------
  logic [7:0] log_b [0:2047];
  int f_start [0:63];
  int f_len [0:63];
  int nframes = 0, nbytes = 0, bits = 0;
  int mosi_err = 0, part_err = 0, hi = 0, min_gap = 1000000;
  int busy_left = 0, busy_cfg = 0;
  logic [7:0] sr = 8'h00;
  logic in_frame = 1'b0, mosi_rise = 1'b0, miso_q = 1'b0;
  logic [7:0] stat;

  assign spi_miso = miso_q;

  always @(negedge spi_cs_n) begin
    in_frame = 1'b1;
    bits = 0;
    miso_q = 1'b0;
    if (nframes < 64) f_start[nframes] = nbytes;
  end

  always @(posedge spi_sck) if (in_frame) begin
    sr = {sr[6:0], spi_mosi};
    mosi_rise = spi_mosi;
    bits++;
    if (bits % 8 == 0 && nbytes < 2048) begin
      log_b[nbytes] = sr;
      nbytes++;
    end
    stat = (busy_left > 0) ? 8'hFF : 8'hFE;
    if (nframes < 64 && bits >= 8 && bits < 16 && log_b[f_start[nframes]] == 8'h05)
      miso_q = stat[15 - bits];
    else
      miso_q = 1'b0;
  end

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 1'b0;
    miso_q = 1'b0;
    if (bits % 8 != 0) part_err++;
    if (nframes < 64) begin
      f_len[nframes] = nbytes - f_start[nframes];
      if (f_len[nframes] > 0) begin
        if (log_b[f_start[nframes]] == 8'h02) busy_left = busy_cfg;
        else if (log_b[f_start[nframes]] == 8'h05 && busy_left > 0) busy_left--;
      end
    end
    nframes++;
  end

  always @(negedge clk) begin
    if (in_frame && spi_sck === 1'b1 && spi_mosi !== mosi_rise) mosi_err++;
    if (spi_cs_n === 1'b1) hi++;
    else begin
      if (hi > 0 && nframes > 0 && hi < min_gap) min_gap = hi;
      hi = 0;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] pat [0:255];
  logic [7:0] exp_b [0:135];

  task automatic clear_log(input int busy_n);
    nframes = 0; nbytes = 0; mosi_err = 0; part_err = 0;
    min_gap = 1000000; busy_cfg = busy_n; busy_left = 0;
  endtask

  task automatic send_req(input int addr, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'(addr); req_len = 16'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic feed(input int len, input int stall_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1'b1; wr_data = pat[i];
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
      #1;
      if (i == stall_at) begin
        wr_valid = 1'b0;
        repeat (45) @(negedge clk);
        // R10: paused frame keeps CS low and SCK low
        check(spi_cs_n == 1'b0 && spi_sck == 1'b0, "R10", "stall pause {cs_n,sck}",
              int'({spi_cs_n, spi_sck}), 0);
      end
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    // R8: single-cycle pulse, block idle again
    check(done == 1'b0, "R8", "done width", int'(done), 0);
    check(req_ready == 1'b1, "R8", "idle after done", int'(req_ready), 1);
  endtask

  task automatic check_frame(input int f, input int elen, input string req, input string what);
    int bad_at;
    bad_at = -1;
    if (f >= 64 || f >= nframes) begin
      check(0, req, {what, " missing frame"}, f, nframes);
      return;
    end
    if (f_len[f] != elen) begin
      check(0, req, {what, " length"}, f_len[f], elen);
      return;
    end
    for (int b = 0; b < elen; b++)
      if (bad_at < 0 && log_b[f_start[f] + b] !== exp_b[b]) bad_at = b;
    if (bad_at < 0) check(1, req, what, 0, 0);
    else check(0, req, {what, " byte"}, int'(log_b[f_start[f] + bad_at]), int'(exp_b[bad_at]));
  endtask

  task automatic verify(input int addr, input int len, input int busy_n);
    int f, a, left, k, c;
    f = 0; a = addr; left = len; k = 0;
    while (left > 0) begin
      c = PAGE - (a % PAGE);
      if (left < c) c = left;
      exp_b[0] = 8'h06;
      check_frame(f, 1, "R3", "arm frame"); f++;
      exp_b[0] = 8'h02; exp_b[1] = 8'(a >> 8); exp_b[2] = 8'(a);
      for (int j = 0; j < c; j++) exp_b[3 + j] = pat[k + j];
      // R5: chunk length from page arithmetic
      if (f < nframes && f < 64) check(f_len[f] == c + 3, "R5", "chunk length", f_len[f] - 3, c);
      check_frame(f, c + 3, "R4", "program frame"); f++;
      for (int p = 0; p <= busy_n; p++) begin
        exp_b[0] = 8'h05; exp_b[1] = 8'h00;
        check_frame(f, 2, "R6", "status poll"); f++;
      end
      a = (a + c) & 16'hFFFF; left -= c; k += c;
    end
    check(nframes == f, "R6", "frame count", nframes, f);
    check(mosi_err == 0, "R2", "mosi moved while SCK high", mosi_err, 0);
    check(part_err == 0, "R4", "frames ending mid-byte", part_err, 0);
    if (f > 1) check(min_gap >= GAP_CYC, "R7", "min CS high cycles", min_gap, GAP_CYC);
  endtask

  task automatic run_write(input int addr, input int len, input int busy_n,
                           input int stall_at, input bit inject);
    clear_log(busy_n);
    for (int i = 0; i < 256; i++) pat[i] = 8'(addr + i * 37 + 11);
    fork
      begin send_req(addr, len); feed(len, stall_at); end
      begin
        if (inject) begin
          repeat (100) @(negedge clk);
          req_valid = 1'b1; req_addr = 16'h5555; req_len = 16'd3;
          @(negedge clk);
          // R8: busy block refuses a new request
          check(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
          req_valid = 1'b0;
        end
      end
      wait_done();
    join
    verify(addr, len, busy_n);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req_valid = 1'b0; wr_valid = 1'b0;
    req_addr = '0; req_len = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1", "cs_n after reset", int'(spi_cs_n), 1);
    check(spi_sck == 1'b0, "R1", "sck after reset", int'(spi_sck), 0);
    check(done == 1'b0, "R1", "done after reset", int'(done), 0);
    check(wr_ready == 1'b0, "R1", "wr_ready after reset", int'(wr_ready), 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic test_zero_len();
    int cyc;
    clear_log(0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 16'h0040; req_len = 16'd0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (done !== 1'b1 && cyc < 10) begin @(negedge clk); cyc++; end
    // R9: completes quickly without a frame
    check(done == 1'b1, "R9", "done for empty request", int'(done), 1);
    repeat (20) @(negedge clk);
    check(nframes == 0, "R9", "frames for empty request", nframes, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    run_write(16'h0010, 1, 2, -1, 1'b0);     // single byte, busy twice
    run_write(16'h007C, 10, 1, -1, 1'b1);    // page crossing, request while busy
    run_write(16'h0100, 128, 0, 5, 1'b0);    // full page with payload stall
    run_write(16'h01F0, 200, 3, -1, 1'b0);   // three chunks, long busy
    run_write(16'hFFFE, 4, 0, -1, 1'b0);     // address wrap
    test_zero_len();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule